// File: doc/BRIEF.md
# Serial ADC Output Port Model

This block is a cycle-based model of the converter side of a 12-bit successive-approximation ADC's serial read port. A host lowers an active-low chip select to start a conversion. The model then holds its data line low for a programmable number of system-clock cycles, which stands in for the conversion time. It drives the line high to flag that the result is ready, and shifts the latched result out MSB-first on falling edges of the host's serial clock.

The data line carries its own end-of-conversion flag, so a host reader can either poll the line for the rising edge or wait out the worst-case conversion time. The frame has a leading 1, then 12 result bits, then zeros for as long as chip select stays low. Raising chip select releases the line and abandons any conversion in progress. Both the serial clock and the chip select are treated as asynchronous and are synchronised to the system clock. A sticky flag records any serial-clock activity during a conversion, which the host is expected not to produce.

The block exists so that host-side serial readers can be verified against a faithful device model.

Top module: `serial_adc_port`

## Requirements
- R1: After reset, `dout_oe_o`, `dout_o` and `clk_err_o` are all 0.
- R2: A falling edge on `cs_ni` enables the output driving 0 exactly SYNC_STAGES+1 system-clock cycles later.
- R3: The data output stays 0 for CONV_CYCLES cycles after it first becomes enabled, then goes to 1 (the leading frame bit and end-of-conversion marker).
- R4: After end of conversion, the n-th falling edge of `sclk_i` (n = 1..12) presents result bit 12-n, so B11 comes first and B0 twelfth.
- R5: Every falling edge of `sclk_i` after B0, while `cs_ni` stays low, presents 0.
- R6: The result is captured from `sample_i` at end of conversion; later changes of `sample_i` do not alter the shifted bits.
- R7: Whenever `cs_ni` rises, `dout_oe_o` drops to 0 (high impedance) SYNC_STAGES+1 cycles later, whatever the state.
- R8: Raising `cs_ni` before end of conversion aborts it. The next falling edge of `cs_ni` starts a complete new conversion of CONV_CYCLES cycles.
- R9: Any `sclk_i` edge during a conversion sets `clk_err_o`. The flag stays set until reset, and the conversion time is not changed.
- R10: Rising edges of `sclk_i` never change `dout_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_ni | input | 1 | Active-low chip select from host (asynchronous) |
| sclk_i | input | 1 | Serial clock from host (asynchronous) |
| sample_i | input | 12 | Conversion result to be reported |
| dout_o | output | 1 | Serial data value |
| dout_oe_o | output | 1 | Data output enable; 0 means high impedance |
| clk_err_o | output | 1 | Sticky flag: serial clock moved during conversion |

## Verification
Three frames are read with result words 0xA5C, 0xFFF and 0x001. The alternating word separates a correct MSB-first order from reversed or shifted orders. The all-ones word shows that the leading 1 and the data are distinct from the trailing zeros. The single low bit catches an off-by-one at B0. The first frame swaps `sample_i` to zero right after end of conversion, which tells a latched result from a live one. Extra falling edges after B0 show the zero fill. An aborted conversion followed by a restart, and a serial-clock pulse during conversion, tell a full conversion-time reload from a resumed count. They also separate a sticky error flag from one that clears itself.

// File: rtl/serial_adc_pkg.sv
package serial_adc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CONV = 2'd1,
    ST_SEND = 2'd2
  } port_state_e;
endpackage

// File: rtl/sadc_sync.sv
module sadc_sync #(
  parameter int          W       = 2,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] level_o,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    logic              prev;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        chain <= {STAGES{RST_VAL[b]}};
        prev  <= RST_VAL[b];
      end else begin
        chain <= {chain[STAGES-2:0], async_i[b]};
        prev  <= chain[STAGES-1];
      end
    end
    assign level_o[b] = chain[STAGES-1];
    assign rise_o[b]  = chain[STAGES-1] & ~prev;
    assign fall_o[b]  = ~chain[STAGES-1] & prev;
  end
endmodule

// File: rtl/sadc_conv_timer.sv
module sadc_conv_timer #(
  parameter int CONV_CYCLES = 938
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic run_i,
  output logic done_o
);
  localparam int CW = $clog2(CONV_CYCLES + 1);
  localparam logic [CW-1:0] RELOAD = CW'(CONV_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (start_i)                cnt_q <= RELOAD;
    else if (run_i && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = run_i && (cnt_q == '0);

  // a fresh start never completes on the following cycle
  assert_no_early_done_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !done_o);
endmodule

// File: rtl/sadc_shifter.sv
module sadc_shifter #(
  parameter int DW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [DW-1:0] data_i,
  input  logic          shift_i,
  output logic          bit_o
);
  logic [DW:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sr_q <= '0;
    else if (load_i)  sr_q <= {1'b1, data_i};
    else if (shift_i) sr_q <= {sr_q[DW-1:0], 1'b0};
  end

  assign bit_o = sr_q[DW];

  assert_frame_lead_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> bit_o);
  assert_hold_no_shift_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !shift_i) |=> $stable(bit_o));
endmodule

// File: rtl/serial_adc_port.sv
module serial_adc_port
  import serial_adc_pkg::*;
#(
  parameter int DATA_W      = 12,
  parameter int CONV_CYCLES = 938,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              sclk_i,
  input  logic [DATA_W-1:0] sample_i,
  output logic              dout_o,
  output logic              dout_oe_o,
  output logic              clk_err_o
);
  localparam int IDX_CS = 1;
  localparam int IDX_SK = 0;

  logic [1:0] lvl, rise, fall;
  port_state_e state_q, state_d;
  logic start, load, shift, done, sr_bit, err_q;

  sadc_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b10)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i({cs_ni, sclk_i}),
    .level_o(lvl),
    .rise_o (rise),
    .fall_o (fall)
  );

  assign start = (state_q == ST_IDLE) && fall[IDX_CS];
  assign load  = (state_q == ST_CONV) && done && !lvl[IDX_CS];
  assign shift = (state_q == ST_SEND) && fall[IDX_SK] && !lvl[IDX_CS];

  sadc_conv_timer #(.CONV_CYCLES(CONV_CYCLES)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start),
    .run_i  (state_q == ST_CONV),
    .done_o (done)
  );

  sadc_shifter #(.DW(DATA_W)) u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .data_i (sample_i),
    .shift_i(shift),
    .bit_o  (sr_bit)
  );

  always_comb begin
    state_d = state_q;
    if (lvl[IDX_CS]) state_d = ST_IDLE;
    else begin
      unique case (state_q)
        ST_IDLE: if (fall[IDX_CS]) state_d = ST_CONV;
        ST_CONV: if (done)         state_d = ST_SEND;
        default: state_d = state_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_CONV && (rise[IDX_SK] || fall[IDX_SK])) err_q <= 1'b1;
    end
  end

  assign dout_oe_o = (state_q != ST_IDLE);
  assign dout_o    = (state_q == ST_SEND) ? sr_bit : 1'b0;
  assign clk_err_o = err_q;

  assert_release_on_cs_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise[IDX_CS] |=> !dout_oe_o);
  assert_start_drives_low_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |=> (dout_oe_o && !dout_o));
  assert_low_while_busy_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_CONV && !done) |=> !dout_o);
  assert_err_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_err_o |=> clk_err_o);
endmodule

// File: tb/tb_serial_adc_port.sv
module tb_serial_adc_port;
  localparam int DW   = 12;
  localparam int CONV = 938;
  localparam int LAT  = 3;   // negedges from input change to output change

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1;
  logic sclk = 1'b0;
  logic [DW-1:0] sample = '0;
  logic dout, dout_oe, clk_err;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  logic [2:0] exp_q[$];
  string      tag_q[$];
  event       smp_ev;

  always #4 clk = ~clk;

  serial_adc_port #(.DATA_W(DW), .CONV_CYCLES(CONV), .SYNC_STAGES(2)) dut (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sclk_i(sclk),
    .sample_i(sample), .dout_o(dout), .dout_oe_o(dout_oe), .clk_err_o(clk_err)
  );

  // monitor: compares {err, oe, dout} against the scoreboard head
  initial begin
    forever begin
      @(smp_ev);
      while (exp_q.size() > 0) begin
        logic [2:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        n_chk++;
        if ({clk_err, dout_oe, dout} !== e) begin
          n_fail++;
          $display("FAIL %s: {err,oe,dout} actual=%b expected=%b at %0t",
                   t, {clk_err, dout_oe, dout}, e, $time);
        end
      end
    end
  end

  task automatic wait_neg(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic expect_now(bit err, bit oe, bit d, string tag);
    exp_q.push_back({err, oe, d});
    tag_q.push_back(tag);
    ->smp_ev;
    #1;
  endtask

  task automatic sclk_rise();
    sclk = 1'b1;
    wait_neg(4);
  endtask

  task automatic sclk_fall();
    sclk = 1'b0;
    wait_neg(4);
  endtask

  // cs low then check the conversion window edges
  task automatic start_conv(bit err, string tag);
    cs_n = 1'b0;
    wait_neg(LAT);
    expect_now(err, 1, 0, {tag, "/R2"});
    wait_neg(CONV - 1);
    expect_now(err, 1, 0, {tag, "/R3 still busy"});
    wait_neg(1);
    expect_now(err, 1, 1, {tag, "/R3 eoc"});
  endtask

  task automatic read_frame(logic [DW-1:0] word, int extra, bit err, string tag);
    for (int i = DW - 1; i >= 0; i--) begin
      logic prev_bit;
      prev_bit = (i == DW - 1) ? 1'b1 : word[i + 1];
      sclk_rise();
      expect_now(err, 1, prev_bit, {tag, "/R10 rise"});
      sclk_fall();
      expect_now(err, 1, word[i], {tag, "/R4 bit"});
    end
    for (int j = 0; j < extra; j++) begin
      sclk_rise();
      sclk_fall();
      expect_now(err, 1, 0, {tag, "/R5 trailing zero"});
    end
  endtask

  task automatic release_cs(bit err, string tag);
    cs_n = 1'b1;
    wait_neg(LAT);
    expect_now(err, 0, 0, {tag, "/R7 hi-z"});
  endtask

  initial begin
    wait_neg(3);
    expect_now(0, 0, 0, "R1 reset");
    rst_n = 1'b1;
    wait_neg(3);
    expect_now(0, 0, 0, "R1 idle");

    // frame 1: latched result, sample changed after EOC
    sample = 12'hA5C;
    start_conv(0, "f1");
    sample = 12'h000;  // R6
    read_frame(12'hA5C, 3, 0, "f1 R6");
    release_cs(0, "f1");

    // abort then full restart
    sample = 12'hFFF;
    wait_neg(6);
    cs_n = 1'b0;
    wait_neg(400);
    expect_now(0, 1, 0, "R8 mid-conv");
    cs_n = 1'b1;
    wait_neg(LAT);
    expect_now(0, 0, 0, "R8 abort released");
    wait_neg(6);
    start_conv(0, "R8 restart");
    read_frame(12'hFFF, 2, 0, "f2");
    release_cs(0, "f2");

    // serial clock during conversion
    sample = 12'h001;
    wait_neg(6);
    cs_n = 1'b0;
    wait_neg(100);
    sclk_rise();
    sclk_fall();
    expect_now(1, 1, 0, "R9 err set");
    wait_neg(CONV + LAT - 1 - 108);
    expect_now(1, 1, 0, "R9 timing unchanged busy");
    wait_neg(1);
    expect_now(1, 1, 1, "R9 timing unchanged eoc");
    read_frame(12'h001, 1, 1, "f3");
    release_cs(1, "f3 R9 sticky");
    wait_neg(10);
    expect_now(1, 0, 0, "R9 still set");

    rst_n = 1'b0;
    wait_neg(2);
    expect_now(0, 0, 0, "R1 reset clears err");
    rst_n = 1'b1;
    wait_neg(2);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule